// File: doc/BRIEF.md
# Immediate Extension Prefix Register

This block lets a multithreaded instruction decoder form full 32-bit immediate operands out of a short 9-bit source field. A prefix instruction decoded for a thread deposits a 23-bit payload into a hidden register that belongs to that thread alone. When the same thread later decodes an instruction with an immediate source, the held payload becomes the upper 23 bits of the operand. The instruction's own 9-bit field becomes the lower bits. The hidden register is then emptied.

The merge is unconditional. The decoder always ORs the selected thread's hidden register above the 9-bit field. An empty register holds zero, so an instruction with no prefix gets the ordinary zero-extended immediate. No flag records whether a prefix came just before. Each hardware thread owns one register. A prefix or a consume only ever touches the register of the thread named on `thread_i`.

The operand path is combinational: the operand and its valid flag appear in the same cycle as the consume strobe. The register updates take effect at the next clock edge.

Top module: `immx_prefix_top`

## Requirements
- R1: A prefix strobe (`pfx_vld_i`=1) stores `pfx_data_i` into the hidden register of thread `thread_i`, and that value is used from the next cycle on.
- R2: During a consume (`use_vld_i`=1), `opnd_o[31:9]` equals the hidden register of thread `thread_i` and `opnd_o[8:0]` equals `use_field_i`.
- R3: After a consume with no prefix for the same thread in that cycle, that thread's hidden register reads zero.
- R4: There are four hidden registers, one per thread, selected by the 2-bit `thread_i`. A prefix or consume for one thread leaves the other three registers unchanged.
- R5: A consume on a thread whose register is zero yields the 9-bit field zero-extended to 32 bits.
- R6: When a prefix and a consume for the same thread occur in the same cycle, the consume uses the old register value and the new payload is stored.
- R7: Reset (`rst_n`=0) clears all four hidden registers to zero.
- R8: A cycle without a consume for a thread, and without a prefix for it, leaves that thread's register unchanged, however many such cycles pass.
- R9: `opnd_vld_o` is 1 exactly in the cycles where `use_vld_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| thread_i | input | 2 | Thread issuing this cycle's strobes |
| pfx_vld_i | input | 1 | A prefix instruction was decoded |
| pfx_data_i | input | 23 | Payload carried by the prefix |
| use_vld_i | input | 1 | An instruction with an immediate source was decoded |
| use_field_i | input | 9 | The instruction's short immediate field |
| opnd_o | output | 32 | Extended immediate operand |
| opnd_vld_o | output | 1 | Operand is valid this cycle |

## Verification
The bench first checks that a register is cleared after it is consumed. A design that kept the payload would corrupt the next immediate with stale upper bits. It then interleaves prefixes and consumes across all four threads. A shared register, or a wrong thread index, would show as one thread's payload appearing in another thread's operand. The same-cycle prefix-and-consume case is exercised in both directions. Getting it wrong either drops the fresh payload or feeds it into the current operand. Idle stretches and all-ones payloads and fields then expose any leakage or decay of the held value, or a misplaced bit boundary.

// File: rtl/immx_pkg.sv
package immx_pkg;
    parameter int NUM_THREADS = 4;
    parameter int PFX_W       = 23;
    parameter int FIELD_W     = 9;
    localparam int OPND_W     = PFX_W + FIELD_W;
    localparam int TID_W      = $clog2(NUM_THREADS);

    typedef logic [PFX_W-1:0]   pfx_t;
    typedef logic [FIELD_W-1:0] field_t;
    typedef logic [OPND_W-1:0]  opnd_t;
endpackage

// File: rtl/immx_slot.sv
module immx_slot
    import immx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_i,
    input  pfx_t wr_data_i,
    input  logic clr_i,
    output pfx_t held_o
);
    pfx_t held_q;

    // A write beats a clear so that a same-cycle prefix survives its consume.
    always_ff @(posedge clk) begin
        if (!rst_n)
            held_q <= '0;
        else if (wr_i)
            held_q <= wr_data_i;
        else if (clr_i)
            held_q <= '0;
    end

    assign held_o = held_q;

    assert_prefix_stored_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> held_o == $past(wr_data_i));

    assert_cleared_after_use_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !wr_i) |=> held_o == '0);

    assert_idle_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !wr_i) |=> $stable(held_o));
endmodule

// File: rtl/immx_merge.sv
module immx_merge
    import immx_pkg::*;
(
    input  pfx_t                   held_i [NUM_THREADS],
    input  logic [TID_W-1:0]       tid_i,
    input  logic                   use_i,
    input  field_t                 field_i,
    output opnd_t                  opnd_o,
    output logic                   vld_o
);
    // Unconditional merge: an empty slot contributes zeros.
    always_comb begin
        opnd_o = {held_i[tid_i], field_i};
        vld_o  = use_i;
    end
endmodule

// File: rtl/immx_prefix_top.sv
module immx_prefix_top
    import immx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TID_W-1:0]  thread_i,
    input  logic              pfx_vld_i,
    input  logic [PFX_W-1:0]  pfx_data_i,
    input  logic              use_vld_i,
    input  logic [FIELD_W-1:0] use_field_i,
    output logic [OPND_W-1:0] opnd_o,
    output logic              opnd_vld_o
);
    pfx_t held [NUM_THREADS];
    logic [NUM_THREADS-1:0] wr_hit;
    logic [NUM_THREADS-1:0] use_hit;

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thread
        always_comb begin
            wr_hit[t]  = pfx_vld_i && (thread_i == TID_W'(t));
            use_hit[t] = use_vld_i && (thread_i == TID_W'(t));
        end

        immx_slot i_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_i      (wr_hit[t]),
            .wr_data_i (pfx_data_i),
            .clr_i     (use_hit[t]),
            .held_o    (held[t])
        );

        assert_upper_zero_after_use_R3: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(use_hit[t] && !wr_hit[t]) && use_hit[t]) |-> opnd_o[OPND_W-1:FIELD_W] == '0);
    end

    immx_merge i_merge (
        .held_i  (held),
        .tid_i   (thread_i),
        .use_i   (use_vld_i),
        .field_i (use_field_i),
        .opnd_o  (opnd_o),
        .vld_o   (opnd_vld_o)
    );

    assert_low_field_R2: assert property (@(posedge clk) disable iff (!rst_n)
        opnd_vld_o |-> opnd_o[FIELD_W-1:0] == use_field_i);
endmodule

// File: tb/test_immx_prefix_top.sv
`timescale 1ns/100ps
module test_immx_prefix_top;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [1:0]  thread_i = 0;
    logic        pfx_vld_i = 0;
    logic [22:0] pfx_data_i = 0;
    logic        use_vld_i = 0;
    logic [8:0]  use_field_i = 0;
    logic [31:0] opnd_o;
    logic        opnd_vld_o;

    int tests = 0;
    int fails = 0;
    logic [22:0] model [4];
    logic [32:0] exp_q [$];
    string       tag_q [$];

    always #2.5 clk = ~clk;

    immx_prefix_top i_immx_prefix_top (
        .clk(clk), .rst_n(rst_n), .thread_i(thread_i),
        .pfx_vld_i(pfx_vld_i), .pfx_data_i(pfx_data_i),
        .use_vld_i(use_vld_i), .use_field_i(use_field_i),
        .opnd_o(opnd_o), .opnd_vld_o(opnd_vld_o)
    );

    // Driver: one cycle of stimulus, pushes the expected result into the scoreboard.
    task automatic issue(input logic [1:0] tid, input logic pv, input logic [22:0] pd,
                         input logic uv, input logic [8:0] uf, input string tag);
        @(posedge clk); #1;
        thread_i = tid; pfx_vld_i = pv; pfx_data_i = pd;
        use_vld_i = uv; use_field_i = uf;
        exp_q.push_back({uv, model[tid], uf});
        tag_q.push_back(tag);
        if (uv) model[tid] = '0;
        if (pv) model[tid] = pd;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) issue(2'd0, 1'b0, '0, 1'b0, '0, "R8/R9 idle");
    endtask

    // Monitor: compares every issued cycle away from the clock edge.
    always @(negedge clk) begin
        if (rst_n && exp_q.size() > 0) begin
            logic [32:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            tests++;
            if (opnd_vld_o !== e[32] || (e[32] && opnd_o !== e[31:0])) begin
                fails++;
                $display("FAIL %s: vld=%0b opnd=%h expected vld=%0b opnd=%h",
                         t, opnd_vld_o, opnd_o, e[32], e[31:0]);
            end
        end
    end

    initial begin
        #100000;
        fails++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int t = 0; t < 4; t++) model[t] = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R7: every thread starts empty; R5 zero extension
        for (int t = 0; t < 4; t++) issue(2'(t), 1'b0, '0, 1'b1, 9'h1A5, "R7 reset state");
        // R1 R2 basic prefix then consume, R3 clear
        issue(2'd1, 1'b1, 23'h2ABCDE, 1'b0, '0, "R9 prefix only");
        issue(2'd1, 1'b0, '0, 1'b1, 9'h033, "R1 R2 merge");
        issue(2'd1, 1'b0, '0, 1'b1, 9'h044, "R3 cleared after use");
        // R4 independence across threads
        issue(2'd0, 1'b1, 23'h000001, 1'b0, '0, "R4 load t0");
        issue(2'd2, 1'b1, 23'h7FFFFF, 1'b0, '0, "R4 load t2");
        issue(2'd3, 1'b1, 23'h155555, 1'b0, '0, "R4 load t3");
        issue(2'd1, 1'b0, '0, 1'b1, 9'h1FF, "R4 t1 untouched");
        issue(2'd3, 1'b0, '0, 1'b1, 9'h000, "R4 t3 own value");
        issue(2'd0, 1'b0, '0, 1'b1, 9'h100, "R4 t0 own value");
        // R8 long idle leaves t2 intact
        idle(20);
        issue(2'd2, 1'b0, '0, 1'b1, 9'h1FF, "R8 held over idle, R2 all ones");
        // R6 same-cycle prefix and consume
        issue(2'd0, 1'b1, 23'h123456, 1'b0, '0, "R6 setup");
        issue(2'd0, 1'b1, 23'h654321, 1'b1, 9'h00F, "R6 old value used");
        issue(2'd0, 1'b0, '0, 1'b1, 9'h0F0, "R6 new value kept");
        issue(2'd0, 1'b1, 23'h0ACE00, 1'b1, 9'h001, "R6 from empty");
        issue(2'd2, 1'b0, '0, 1'b1, 9'h002, "R4 R5 other thread empty");
        issue(2'd0, 1'b0, '0, 1'b1, 9'h003, "R6 stored after empty");
        issue(2'd0, 1'b0, '0, 1'b1, 9'h004, "R5 no prefix zero extend");
        // R7 reset mid-run clears pending payloads
        issue(2'd3, 1'b1, 23'h3C3C3C, 1'b0, '0, "R7 setup");
        @(posedge clk); #1;
        thread_i = 0; pfx_vld_i = 0; use_vld_i = 0;
        rst_n = 0;
        @(posedge clk); #1 rst_n = 1;
        for (int t = 0; t < 4; t++) model[t] = '0;
        issue(2'd3, 1'b0, '0, 1'b1, 9'h0AA, "R7 reset clears");
        idle(2);
        @(posedge clk); #1 use_vld_i = 0; pfx_vld_i = 0;
        @(negedge clk); @(negedge clk);
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R9: pending=%0d expected=0", exp_q.size());
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule